// File: doc/BRIEF.md
# 128-bit Pseudo-Random Number Source

This block keeps a 128-stage linear feedback shift register running so that a fresh pseudo-random 128-bit number is always at hand for authentication and key derivation. On request it copies the register into a holding register that drives a parallel output. It then streams that held value out one bit per clock, most significant bit first, with a flag on the first bit and a busy output that covers the whole transfer.

Feedback can be switched off. The register then acts as a plain serial-in shift register, so that a random number supplied from outside (for example by the peer device) can be clocked in bit by bit. A stall input freezes the register while a security algorithm is running. The readout path does not depend on stall or on the feedback mode.

Top module: `rng128_top`

## Requirements
- R1: While rst is high and after it is released, every register stage is 0, number_q is 0, and stream_bit, stream_first and stream_busy are 0.
- R2: With feedback_on=1 and stall=0, each clock shifts the register one place toward the MSB. The new bit 0 is the XNOR of bits 127, 125, 100 and 8 (tap positions 128, 126, 101 and 9 counted from 1). Starting from all zeros, five clocks give 128'h1F.
- R3: With feedback_on=0 and stall=0, each clock shifts load_bit into bit 0. After 128 such clocks, the first bit shifted in sits in bit 127.
- R4: While stall is high, the register keeps its value in both modes.
- R5: A capture_req seen while stream_busy is 0 copies the register value present in that cycle (before that edge's shift) into number_q from the next cycle. number_q then holds until the next accepted capture.
- R6: stream_bit shows number_q bit 127 in the first busy cycle, then bit 126, and so on down to bit 0 in the 128th busy cycle. It is 0 whenever stream_busy is 0.
- R7: stream_first is high in the first busy cycle of a readout and in no other cycle.
- R8: After an accepted capture, stream_busy is high for exactly 128 cycles. A capture_req while stream_busy is high, including in its last cycle, is ignored: number_q stays the same and the readout is not restarted. A request in the first idle cycle is accepted.
- R9: A capture and a register shift may share one edge, and a capture taken while stall is high still streams its full 128 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| feedback_on | input | 1 | 1 = run as LFSR, 0 = serial load from load_bit |
| load_bit | input | 1 | Serial data shifted into bit 0 when feedback is off |
| capture_req | input | 1 | Request to capture and stream a number |
| stall | input | 1 | Freezes the register while high |
| number_q | output | 128 | Last captured number |
| stream_bit | output | 1 | Serial readout, MSB first |
| stream_first | output | 1 | Marks the first serial bit |
| stream_busy | output | 1 | High for the 128 cycles of a readout |

## Verification
Two functions can share an edge: a capture and the register's own advance. The bench raises capture_req while the register keeps shifting, and checks that number_q equals the value from before that edge. The same case is repeated with stall high, where it also confirms the stream still runs. A second overlap is a new request against the readout counter. Requests are issued in the middle of a transfer and on its final busy cycle. The checks judge these by the unchanged number_q, a busy window of exactly 128 cycles, and acceptance of a request on the first idle cycle.

// File: rtl/rng128_pkg.sv
package rng128_pkg;

    localparam int unsigned RNG_W   = 128;
    localparam int unsigned TAP_CNT = 4;
    localparam int unsigned CNT_W   = $clog2(RNG_W);

    // Tap positions counted from 1; position 128 is the MSB.
    localparam int unsigned TAP_POS [TAP_CNT] = '{128, 126, 101, 9};

    typedef struct packed {
        logic [RNG_W-1:0] bits;
    } lfsr_st_t;

    typedef struct packed {
        logic [RNG_W-1:0] held;
        logic [CNT_W-1:0] idx;
        logic             active;
    } rdout_st_t;

endpackage

// File: rtl/rng128_taps.sv
module rng128_taps
    import rng128_pkg::*;
(
    input  logic [RNG_W-1:0] state_i,
    output logic             fb_o
);

    logic [TAP_CNT-1:0] tap_v;

    for (genvar g = 0; g < TAP_CNT; g++) begin : g_tap
        assign tap_v[g] = state_i[TAP_POS[g]-1];
    end

    // XNOR form: all zeros is a legal state, all ones locks up.
    assign fb_o = ~(^tap_v);

endmodule

// File: rtl/rng128_lfsr.sv
module rng128_lfsr
    import rng128_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fb_on,
    input  logic             ser_bit,
    input  logic             stall,
    input  logic             fb_bit,
    output logic [RNG_W-1:0] state_o
);

    lfsr_st_t st_d, st_q;
    logic     new_bit;

    always_comb begin
        st_d    = st_q;
        new_bit = fb_on ? fb_bit : ser_bit;
        if (!stall) begin
            st_d.bits = {st_q.bits[RNG_W-2:0], new_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.bits;

endmodule

// File: rtl/rng128_readout.sv
module rng128_readout
    import rng128_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [RNG_W-1:0] state_i,
    output logic [RNG_W-1:0] held_o,
    output logic             bit_o,
    output logic             first_o,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RNG_W - 1);

    rdout_st_t        rd_d, rd_q;
    logic [CNT_W-1:0] sel;

    always_comb begin
        rd_d = rd_q;
        if (rd_q.active) begin
            if (rd_q.idx == LAST_IDX) begin
                rd_d.active = 1'b0;
                rd_d.idx    = '0;
            end else begin
                rd_d.idx = rd_q.idx + 1'b1;
            end
        end else if (req) begin
            rd_d.held   = state_i;
            rd_d.active = 1'b1;
            rd_d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign sel     = LAST_IDX - rd_q.idx;
    assign held_o  = rd_q.held;
    assign bit_o   = rd_q.active & rd_q.held[sel];
    assign first_o = rd_q.active & (rd_q.idx == '0);
    assign busy_o  = rd_q.active;

endmodule

// File: rtl/rng128_top.sv
module rng128_top
    import rng128_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             feedback_on,
    input  logic             load_bit,
    input  logic             capture_req,
    input  logic             stall,
    output logic [RNG_W-1:0] number_q,
    output logic             stream_bit,
    output logic             stream_first,
    output logic             stream_busy
);

    logic [RNG_W-1:0] lfsr_state;
    logic             fb_bit;

    rng128_taps u_taps (
        .state_i (lfsr_state),
        .fb_o    (fb_bit)
    );

    rng128_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .fb_on   (feedback_on),
        .ser_bit (load_bit),
        .stall   (stall),
        .fb_bit  (fb_bit),
        .state_o (lfsr_state)
    );

    rng128_readout u_rd (
        .clk     (clk),
        .rst     (rst),
        .req     (capture_req),
        .state_i (lfsr_state),
        .held_o  (number_q),
        .bit_o   (stream_bit),
        .first_o (stream_first),
        .busy_o  (stream_busy)
    );

endmodule

// File: rtl/rng128_chk.sv
module rng128_chk
    import rng128_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             capture_req,
    input  logic [RNG_W-1:0] state,
    input  logic [RNG_W-1:0] number_q,
    input  logic             stream_bit,
    input  logic             stream_first,
    input  logic             stream_busy
);

    logic [CNT_W:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !stream_busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_stall_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        stall |=> (state == $past(state)));

    assert_capture_value_R5: assert property (@(posedge clk) disable iff (rst)
        (capture_req && !stream_busy) |=> (number_q == $past(state)));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !stream_busy |-> !stream_bit);

    assert_first_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
        stream_first |-> stream_busy);

    assert_first_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stream_busy) |-> stream_first);

    assert_window_bound_R8: assert property (@(posedge clk) disable iff (rst)
        stream_busy |-> (busy_cnt < (CNT_W+1)'(RNG_W)));

    assert_window_length_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(stream_busy) |-> (busy_cnt == (CNT_W+1)'(RNG_W)));

    assert_held_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (stream_busy && $past(stream_busy)) |-> $stable(number_q));

endmodule

bind rng128_top rng128_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .stall        (stall),
    .capture_req  (capture_req),
    .state        (lfsr_state),
    .number_q     (number_q),
    .stream_bit   (stream_bit),
    .stream_first (stream_first),
    .stream_busy  (stream_busy)
);

// File: tb/rng128_top_tb.sv
module rng128_top_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         feedback_on;
    logic         load_bit;
    logic         capture_req;
    logic         stall;
    logic [127:0] number_q;
    logic         stream_bit;
    logic         stream_first;
    logic         stream_busy;

    int           checks = 0;
    int           errors = 0;
    logic [127:0] m;
    logic [127:0] pre;

    always #4 clk = ~clk;

    rng128_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .feedback_on  (feedback_on),
        .load_bit     (load_bit),
        .capture_req  (capture_req),
        .stall        (stall),
        .number_q     (number_q),
        .stream_bit   (stream_bit),
        .stream_first (stream_first),
        .stream_busy  (stream_busy)
    );

    // Row: feedback_on, pattern select(2), stall, cycles(8)
    localparam logic [11:0] VEC [7] = '{
        {1'b1, 2'd0, 1'b0, 8'd5},
        {1'b1, 2'd0, 1'b0, 8'd200},
        {1'b0, 2'd2, 1'b0, 8'd128},
        {1'b1, 2'd0, 1'b1, 8'd40},
        {1'b0, 2'd3, 1'b0, 8'd60},
        {1'b1, 2'd0, 1'b0, 8'd90},
        {1'b0, 2'd1, 1'b1, 8'd30}
    };

    function automatic logic pat(input logic [1:0] sel, input int i);
        case (sel)
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return i[0];
            default: return i[2] ^ i[0];
        endcase
    endfunction

    task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Drive at negedge, model the register at the edge, sample 2 ns later.
    task automatic step(input logic fb, input logic ib, input logic rq, input logic st);
        @(negedge clk);
        feedback_on = fb;
        load_bit    = ib;
        capture_req = rq;
        stall       = st;
        pre         = m;
        @(posedge clk);
        if (!st) m = {m[126:0], fb ? ~(m[127] ^ m[125] ^ m[100] ^ m[8]) : ib};
        #2;
    endtask

    task automatic readout(input logic [127:0] exp, input logic fb, input logic [1:0] sel,
                           input logic st, input int rq_a, input int rq_b);
        logic [127:0] got   = '0;
        int           firsts = 0;
        int           firstpos = -1;
        int           busyc  = 0;
        for (int i = 0; i < 128; i++) begin
            got[127-i] = stream_bit;
            if (stream_first) begin firsts++; firstpos = i; end
            if (stream_busy) busyc++;
            step(fb, pat(sel, i), (i == rq_a) || (i == rq_b), st);
        end
        check("R6 serial order", got, exp);
        check("R7 first flag", {64'(firsts), 64'(firstpos)}, {64'd1, 64'd0});
        check("R8 busy length", {127'(busyc), stream_busy}, {127'd128, 1'b0});
        check("R8 held after readout", number_q, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] start;
        rst = 1'b1; feedback_on = 1'b0; load_bit = 1'b0; capture_req = 1'b0; stall = 1'b0;
        m = '0; pre = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset outputs", {number_q[127:3], stream_bit, stream_first, stream_busy}, '0);
        @(negedge clk);
        rst = 1'b0;
        #5;
        check("R1 after release", {number_q[127:3], stream_bit, stream_first, stream_busy}, '0);

        // Table of vectors
        for (int r = 0; r < 7; r++) begin
            start = m;
            for (int i = 0; i < int'(VEC[r][7:0]); i++)
                step(VEC[r][11], pat(VEC[r][10:9], i), 1'b0, VEC[r][8]);
            step(VEC[r][11], 1'b0, 1'b1, 1'b0);
            if (r == 0) check("R1 R2 five clocks from zero", number_q, 128'h1F);
            if (VEC[r][8]) check("R4 stall freeze", number_q, start);
            else if (!VEC[r][11]) check("R3 serial load", number_q, pre);
            else check("R5 capture value", number_q, pre);
            check("R7 first on capture", {stream_busy, stream_first}, 2'b11);
            readout(pre, VEC[r][11], VEC[r][10:9], 1'b0, -1, -1);
        end

        // R3: known pattern fully loaded, first bit lands in bit 127
        for (int i = 0; i < 128; i++) step(1'b0, (i % 3) == 0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        begin
            logic [127:0] ld;
            for (int i = 0; i < 128; i++) ld[127-i] = ((i % 3) == 0);
            check("R3 load order", number_q, ld);
        end
        readout(pre, 1'b1, 2'd0, 1'b0, -1, -1);

        // R8: requests mid-readout and on the last busy cycle are ignored
        for (int i = 0; i < 17; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        start = pre;
        readout(start, 1'b1, 2'd0, 1'b0, 60, 127);
        check("R8 ignored requests keep number", number_q, start);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R8 first idle request accepted", {stream_busy, number_q}, {1'b1, pre});
        readout(pre, 1'b1, 2'd0, 1'b0, -1, -1);

        // R9: capture with stall high; readout runs while stalled throughout
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b1);
        start = pre;
        check("R9 capture under stall", number_q, start);
        readout(start, 1'b1, 2'd0, 1'b1, -1, -1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 R4 state frozen across stalled readout", number_q, start);
        readout(start, 1'b1, 2'd0, 1'b0, -1, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule